// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds operations that are waiting to run on one functional unit of a dynamically scheduled core, for example a floating-point adder. An issue stage hands it an operation code and two sources. Each source comes either as a finished value or as the tag of the station that will produce that value. A source that is still missing is filled by watching a single result broadcast bus, which carries a producer tag and its data. When the broadcast tag equals the tag the source is waiting for, the entry copies the data. No register file is read at dispatch, because every entry collects its own operands.

Each cycle, at most one entry whose two operands are both present is offered to the functional unit. The offer carries the opcode, both operand values and the tag of the entry. That tag is the name the unit later broadcasts with its result. When the result with that tag appears on the bus, the entry becomes free again. Every entry has its own fixed global tag, equal to `TAG_BASE` plus its index. Tag value 0 is reserved and means "no producer, value present".

The issue port follows valid/ready rules. An operation is taken on a cycle where `iss_valid` and `iss_ready` are both high. `iss_ready` is low exactly when every entry is occupied, and an offered operation then simply waits. The dispatch port also follows valid/ready rules. An entry leaves on a cycle where `dsp_valid` and `dsp_ready` are both high. While `dsp_ready` is low, `dsp_valid` stays high. The offered entry may still change if a lower-index entry wakes up in the meantime. The result bus has no back-pressure.

Top module: `rs_bank`

## Requirements
- R1: After a synchronous reset every entry is free: `full` is 0, `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An operation is accepted only when some entry is free. Once all `NUM_ENT` entries hold operations, `full` is 1 and `iss_ready` is 0, and an operation offered on `iss_valid` in that state is not stored.
- R3: A new operation goes into the lowest-index free entry. Entry i is named by tag `TAG_BASE + i`, which is tags 1 to 4 with the defaults. A source tag of 0 means the value given with it is ready.
- R4: An entry is offered on the dispatch port only when both of its operands are ready. The offer presents its opcode, both values and its own tag. An entry that has been dispatched is not offered again.
- R5: A waiting source whose stored tag equals `res_tag` while `res_valid` is 1 takes `res_data` and becomes ready. Both sources of one entry may wake from the same broadcast. The entry can be offered from the cycle after the broadcast.
- R6: If an operation is accepted in the same cycle as a broadcast whose tag equals one of its source tags, that source stores the broadcast data and is ready. The wakeup is not lost.
- R7: When several entries are ready, the lowest index is offered. At most one entry leaves per cycle, and none leaves while `dsp_ready` is 0.
- R8: A dispatched entry becomes free when a broadcast with its own tag appears. In that same cycle, the broadcast can also wake other entries.
- R9: A broadcast with a non-matching tag, or with `res_valid` at 0, leaves waiting sources unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue stage offers an operation |
| iss_ready | output | 1 | A free entry exists, so the offer is taken |
| iss_op | input | OP_W | Operation code |
| iss_a_tag | input | TAG_W | Producer tag of source A, 0 when value is ready |
| iss_a_val | input | DATA_W | Value of source A when its tag is 0 |
| iss_b_tag | input | TAG_W | Producer tag of source B, 0 when value is ready |
| iss_b_val | input | DATA_W | Value of source B when its tag is 0 |
| res_valid | input | 1 | Result broadcast present this cycle |
| res_tag | input | TAG_W | Tag of the station that produced the result |
| res_data | input | DATA_W | Result data |
| dsp_valid | output | 1 | A ready entry is offered to the unit |
| dsp_ready | input | 1 | Functional unit can take an operation |
| dsp_op | output | OP_W | Opcode of the offered entry |
| dsp_tag | output | TAG_W | Tag of the offered entry |
| dsp_a | output | DATA_W | Source A value of the offered entry |
| dsp_b | output | DATA_W | Source B value of the offered entry |
| full | output | 1 | Every entry is occupied |

## Verification
The wakeup path is driven in four ways: with ready values, with a tag that a later broadcast completes, with both sources waiting on one tag, and with a tag whose broadcast arrives in the very cycle of issue. Together these separate capture at issue, capture by snooping, and the same-cycle bypass. Broadcasts with foreign tags and with `res_valid` low show that unrelated bus traffic leaves waiting sources alone. Waking entries out of index order, then holding `dsp_ready` low, shows that the selection goes by index and not by arrival, and that the unit's back-pressure is respected. Filling the bank, and running a dependent pair where one broadcast both frees the producer and wakes the consumer, covers the full stall, the reuse of a freed entry and the release path.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Life cycle of one station slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_HELD = 2'd1,
    SLOT_SENT = 2'd2
  } slot_state_t;
endpackage

// File: rtl/rs_operand.sv
// One source operand: holds either a value (tag zero) or a producer tag.
module rs_operand #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] load_val,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              bypass_hit;
  logic              snoop_hit;

  always_comb begin
    bypass_hit = res_valid && (res_tag == load_tag);
    snoop_hit  = res_valid && (tag_q != '0) && (res_tag == tag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (load) begin
      if (load_tag == '0) begin
        tag_q <= '0;
        val_q <= load_val;
      end else if (bypass_hit) begin
        tag_q <= '0;
        val_q <= res_data;
      end else begin
        tag_q <= load_tag;
        val_q <= '0;
      end
    end else if (snoop_hit) begin
      tag_q <= '0;
      val_q <= res_data;
    end
  end

  assign rdy = (tag_q == '0);
  assign val = val_q;

  // R5: a waiting source picks up a matching broadcast
  assert_wakeup_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !rdy && res_valid && res_tag == tag_q) |=> (rdy && val == $past(res_data)));

  // R6: same-cycle broadcast is captured at load
  assert_issue_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (load && load_tag != '0 && res_valid && res_tag == load_tag) |=> (rdy && val == $past(res_data)));

  // R9: unrelated bus traffic leaves a waiting source alone
  assert_no_false_wake_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !rdy && !(res_valid && res_tag == tag_q)) |=> (!rdy && $stable(val)));
endmodule

// File: rtl/rs_pick.sv
// Lowest-index-first one-hot picker.
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any = |req;
  end

  // R7: at most one winner, and one whenever there is a request
  always_comb begin
    assert_grant_onehot_R7: assert ($onehot0(grant));
    if (any) begin
      assert_grant_present_R7: assert (grant != '0);
    end
  end
endmodule

// File: rtl/rs_entry.sv
// One reservation station: opcode, two operands and a slot state.
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   op_in,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_val,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_val,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              fire,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b
);
  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

  slot_state_t     state;
  logic [OP_W-1:0] op_q;
  logic            a_rdy;
  logic            b_rdy;
  logic            own_result;

  assign own_result = res_valid && (res_tag == OWN_TAG);

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
    .clk(clk), .rst(rst), .load(alloc), .load_tag(a_tag), .load_val(a_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .rdy(a_rdy), .val(a)
  );

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
    .clk(clk), .rst(rst), .load(alloc), .load_tag(b_tag), .load_val(b_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .rdy(b_rdy), .val(b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SLOT_FREE;
      op_q  <= '0;
    end else begin
      case (state)
        SLOT_FREE: if (alloc) begin
          state <= SLOT_HELD;
          op_q  <= op_in;
        end
        SLOT_HELD: if (fire) state <= SLOT_SENT;
        SLOT_SENT: if (own_result) state <= SLOT_FREE;
        default:   state <= SLOT_FREE;
      endcase
    end
  end

  assign busy  = (state != SLOT_FREE);
  assign ready = (state == SLOT_HELD) && a_rdy && b_rdy;
  assign op    = op_q;

  // R2: only free slots are written
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (state == SLOT_FREE));

  // R4: only a complete, not yet dispatched slot leaves
  assert_fire_complete_R4: assert property (@(posedge clk) disable iff (rst)
    fire |-> (state == SLOT_HELD && a_rdy && b_rdy));

  // R8: own broadcast releases a dispatched slot
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SLOT_SENT && own_result) |=> (state == SLOT_FREE));
endmodule

// File: rtl/rs_bank.sv
// Bank of reservation stations in front of one functional unit.
module rs_bank #(
  parameter int NUM_ENT  = 4,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic [TAG_W-1:0]  dsp_tag,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b,
  output logic              full
);
  logic [NUM_ENT-1:0] busy_vec;
  logic [NUM_ENT-1:0] ready_vec;
  logic [NUM_ENT-1:0] free_grant;
  logic [NUM_ENT-1:0] disp_grant;
  logic [NUM_ENT-1:0] alloc_vec;
  logic [NUM_ENT-1:0] fire_vec;
  logic               free_any;
  logic               iss_fire;
  logic               dsp_fire;

  logic [OP_W-1:0]   op_arr [NUM_ENT];
  logic [DATA_W-1:0] a_arr  [NUM_ENT];
  logic [DATA_W-1:0] b_arr  [NUM_ENT];

  rs_pick #(.N(NUM_ENT)) u_free_pick (
    .req(~busy_vec), .grant(free_grant), .any(free_any)
  );

  rs_pick #(.N(NUM_ENT)) u_disp_pick (
    .req(ready_vec), .grant(disp_grant), .any(dsp_valid)
  );

  assign iss_ready = free_any;
  assign full      = !free_any;
  assign iss_fire  = iss_valid && free_any;
  assign dsp_fire  = dsp_valid && dsp_ready;
  assign alloc_vec = free_grant & {NUM_ENT{iss_fire}};
  assign fire_vec  = disp_grant & {NUM_ENT{dsp_fire}};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(TAG_BASE + g)
    ) u_ent (
      .clk(clk), .rst(rst), .alloc(alloc_vec[g]), .op_in(iss_op),
      .a_tag(iss_a_tag), .a_val(iss_a_val), .b_tag(iss_b_tag), .b_val(iss_b_val),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .fire(fire_vec[g]), .busy(busy_vec[g]), .ready(ready_vec[g]),
      .op(op_arr[g]), .a(a_arr[g]), .b(b_arr[g])
    );
  end

  // One-hot select of the offered entry.
  always_comb begin
    dsp_op  = '0;
    dsp_tag = '0;
    dsp_a   = '0;
    dsp_b   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (disp_grant[i]) begin
        dsp_op  = op_arr[i];
        dsp_tag = TAG_W'(TAG_BASE + i);
        dsp_a   = a_arr[i];
        dsp_b   = b_arr[i];
      end
    end
  end

  // R2: nothing new enters while every entry is taken
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    full |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

  // R7: a held-off offer is not withdrawn
  assert_offer_held_R7: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !dsp_ready) |=> dsp_valid);

  // R7: one departure per cycle
  assert_single_fire_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(fire_vec) <= 1);
endmodule

// File: tb/rs_bank_bench.sv
module rs_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int OW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [OW-1:0] iss_op = '0;
  logic [TW-1:0] iss_a_tag = '0;
  logic [DW-1:0] iss_a_val = '0;
  logic [TW-1:0] iss_b_tag = '0;
  logic [DW-1:0] iss_b_val = '0;
  logic          res_valid = 1'b0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic          dsp_valid;
  logic          dsp_ready = 1'b0;
  logic [OW-1:0] dsp_op;
  logic [TW-1:0] dsp_tag;
  logic [DW-1:0] dsp_a;
  logic [DW-1:0] dsp_b;
  logic          full;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  rs_bank u_rs_bank (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
    .dsp_tag(dsp_tag), .dsp_a(dsp_a), .dsp_b(dsp_b), .full(full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; iss_valid = 1'b0; res_valid = 1'b0; dsp_ready = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic issue(input logic [OW-1:0] op, input logic [TW-1:0] at, input logic [DW-1:0] av,
                       input logic [TW-1:0] bt, input logic [DW-1:0] bv);
    iss_op = op; iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
    iss_valid = 1'b1;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
    res_tag = t; res_data = d; res_valid = 1'b1;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 full", full, 0);
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 dsp_valid", dsp_valid, 0);
  endtask

  task automatic t_ready_values();
    do_reset();
    issue(4'd5, 0, 32'h10, 0, 32'h20);
    chk("R4 valid", dsp_valid, 1);
    chk("R3 tag entry0", dsp_tag, 1);
    chk("R4 op", dsp_op, 5);
    chk("R4 a", dsp_a, 32'h10);
    chk("R4 b", dsp_b, 32'h20);
    dsp_ready = 1'b1; tick(); dsp_ready = 1'b0;
    chk("R4 no redispatch", dsp_valid, 0);
    bcast(1, 32'h30);
    issue(4'd6, 0, 32'h1, 0, 32'h2);
    chk("R8 entry0 reused", dsp_tag, 1);
  endtask

  task automatic t_snoop();
    do_reset();
    issue(4'd2, 9, 32'h0, 0, 32'h7);
    chk("R4 waits", dsp_valid, 0);
    bcast(10, 32'h55);
    chk("R9 foreign tag", dsp_valid, 0);
    res_tag = 9; res_data = 32'h66; res_valid = 1'b0; tick();
    chk("R9 invalid bus", dsp_valid, 0);
    bcast(9, 32'h33);
    chk("R5 woken", dsp_valid, 1);
    chk("R5 a captured", dsp_a, 32'h33);
    chk("R5 b kept", dsp_b, 32'h7);
  endtask

  task automatic t_same_tag();
    do_reset();
    issue(4'd3, 9, 32'h0, 9, 32'h0);
    bcast(9, 32'h44);
    chk("R5 both valid", dsp_valid, 1);
    chk("R5 both a", dsp_a, 32'h44);
    chk("R5 both b", dsp_b, 32'h44);
  endtask

  task automatic t_bypass();
    do_reset();
    res_tag = 11; res_data = 32'h99; res_valid = 1'b1;
    issue(4'd1, 11, 32'h0, 0, 32'h5);
    res_valid = 1'b0;
    chk("R6 bypass valid", dsp_valid, 1);
    chk("R6 bypass data", dsp_a, 32'h99);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 4; i++) issue(4'd1, 9, 0, 0, i);
    chk("R2 full", full, 1);
    chk("R2 iss_ready", iss_ready, 0);
    issue(4'd7, 0, 32'h1, 0, 32'h2);
    chk("R2 rejected", dsp_valid, 0);
    bcast(9, 32'h5);
    chk("R7 lowest", dsp_tag, 1);
    chk("R2 still full", full, 1);
  endtask

  task automatic t_priority();
    do_reset();
    issue(4'd1, 9, 0, 0, 0);
    issue(4'd2, 10, 0, 0, 0);
    issue(4'd3, 11, 0, 0, 0);
    bcast(10, 32'h20);
    chk("R7 only ready", dsp_tag, 2);
    chk("R7 only ready a", dsp_a, 32'h20);
    bcast(9, 32'h10);
    chk("R7 lower wins", dsp_tag, 1);
    tick();
    chk("R7 held no ready", dsp_tag, 1);
    dsp_ready = 1'b1; tick(); dsp_ready = 1'b0;
    chk("R7 one per cycle", dsp_tag, 2);
    bcast(1, 32'h0);
    issue(4'd4, 0, 32'h3, 0, 32'h3);
    chk("R8 freed reused", dsp_tag, 1);
    chk("R8 freed op", dsp_op, 4);
  endtask

  task automatic t_chain();
    do_reset();
    issue(4'd1, 0, 32'h3, 0, 32'h4);
    issue(4'd1, 1, 32'h0, 0, 32'ha);
    chk("R4 producer first", dsp_tag, 1);
    dsp_ready = 1'b1; tick(); dsp_ready = 1'b0;
    chk("R4 consumer waits", dsp_valid, 0);
    bcast(1, 32'h7);
    chk("R8 consumer woken", dsp_tag, 2);
    chk("R8 consumer a", dsp_a, 32'h7);
    chk("R8 consumer b", dsp_b, 32'ha);
    issue(4'd2, 0, 0, 0, 0);
    chk("R8 producer freed", dsp_tag, 1);
  endtask

  initial begin
    t_reset();
    t_ready_values();
    t_snoop();
    t_same_tag();
    t_bypass();
    t_full();
    t_priority();
    t_chain();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule